// File: doc/BRIEF.md
# Multi-driver bus value resolver

This block computes the value a shared, multi-driver bus line would carry when several sources may drive it at once. Each of N sources presents an enable and a W-bit word in which every bit is a two-bit four-state code. A source whose enable is low takes no part. The enabled contributions are then merged bit by bit into a single four-state word that follows the usual wired-bus rules. X wins over everything. A 0 meeting a 1 gives X. A driven 0 or 1 wins over high impedance. High impedance remains only where nothing drives.

The block also reports bus discipline. A contention flag rises when more than one source is enabled in the same cycle, even if the values agree. An idle flag rises when no source is enabled, and the raw set of enabled sources is passed out as a mask. All of these results are combinational. A parameter adds a registered copy of the resolved word and of both flags. A synchronous reset clears that copy to an all-high-impedance, idle bus. No real bidirectional pads are modelled: the four-state value travels as ordinary two-bit codes.

Top module: `bus_resolver`

## Requirements
- R1: Four-state codes are 2'b00 = 0, 2'b01 = 1, 2'b10 = Z and 2'b11 = X. Bit i of a word sits in bits [2i+1:2i]. Driver d occupies drv_val[d*2W +: 2W].
- R2: A source whose enable is low contributes Z, whatever its data, so it never changes res_comb.
- R3: On any bit where enabled sources contribute both 0 and 1, the resolved bit is X.
- R4: On any bit where any enabled source contributes X, the resolved bit is X.
- R5: A driven 0 or 1 passes unchanged when every other contribution to that bit is Z or the same value.
- R6: A resolved bit is Z only when every contribution to it is Z, including enabled sources that feed the Z code.
- R7: contention is 1 exactly when two or more enables are high, even when their values agree.
- R8: idle is 1 exactly when no enable is high, and active_mask equals drv_en.
- R9: With REG_OUT=1, res_q, contention_q and idle_q equal the previous cycle's res_comb, contention and idle after each rising edge with rst low.
- R10: A rising edge with rst high sets res_q to all Z, contention_q to 0 and idle_q to 1. It has no effect on the combinational outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered copy |
| rst | input | 1 | Synchronous active-high reset of the registered copy |
| drv_en | input | N | Per-source drive enable |
| drv_val | input | N*2*W | Per-source four-state words, source 0 in the lowest bits |
| res_comb | output | 2*W | Resolved four-state word, combinational |
| contention | output | 1 | More than one source enabled, combinational |
| idle | output | 1 | No source enabled, combinational |
| active_mask | output | N | Enabled sources |
| res_q | output | 2*W | Registered resolved word |
| contention_q | output | 1 | Registered contention flag |
| idle_q | output | 1 | Registered idle flag |

## Verification
A wrong merge rule shows at once on res_comb, in the same cycle, as a bit that reads 0, 1 or Z where X is due, or the other way round. The stimulus therefore pairs every combination of codes across enabled and disabled sources. A fault in the enable-count logic shows in the same cycle on contention or idle. The agreeing-drivers case and the lone-driver case separate a "values differ" test from a true "more than one enabled" test. A fault in the registered copy appears one edge later on res_q and its flags, and reset faults appear on the first edge after rst rises.

// File: rtl/bus_res_pkg.sv
package bus_res_pkg;
  typedef logic [1:0] lane_t;

  localparam lane_t LANE_0 = 2'b00;
  localparam lane_t LANE_1 = 2'b01;
  localparam lane_t LANE_Z = 2'b10;
  localparam lane_t LANE_X = 2'b11;

  // wired-bus merge of two contributions; associative and commutative
  function automatic lane_t lane_merge(input lane_t a, input lane_t b);
    lane_t r;
    if (a == LANE_X || b == LANE_X) r = LANE_X;
    else if (a == LANE_Z)           r = b;
    else if (b == LANE_Z)           r = a;
    else if (a != b)                r = LANE_X;
    else                            r = a;
    return r;
  endfunction
endpackage

// File: rtl/bres_gate.sv
module bres_gate #(
  parameter int W = 8
) (
  input  logic           en,
  input  logic [2*W-1:0] val,
  output logic [2*W-1:0] contrib
);
  import bus_res_pkg::*;

  // an idle source floats every bit
  always_comb begin
    for (int b = 0; b < W; b++) begin
      contrib[2*b +: 2] = en ? val[2*b +: 2] : LANE_Z;
    end
  end
endmodule

// File: rtl/bres_lane.sv
module bres_lane #(
  parameter int N = 4
) (
  input  logic [2*N-1:0] col,
  output logic [1:0]     res
);
  import bus_res_pkg::*;

  always_comb begin
    lane_t acc;
    acc = LANE_Z;
    for (int d = 0; d < N; d++) begin
      acc = lane_merge(acc, col[2*d +: 2]);
    end
    res = acc;
  end
endmodule

// File: rtl/bres_flags.sv
module bres_flags #(
  parameter int N = 4
) (
  input  logic [N-1:0] en,
  output logic         multi,
  output logic         none
);
  // clearing the lowest set bit leaves something only when two or more are set
  assign multi = |(en & (en - N'(1)));
  assign none  = ~|en;
endmodule

// File: rtl/bus_resolver.sv
module bus_resolver #(
  parameter int N       = 4,
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       drv_en,
  input  logic [N*2*W-1:0]   drv_val,
  output logic [2*W-1:0]     res_comb,
  output logic               contention,
  output logic               idle,
  output logic [N-1:0]       active_mask,
  output logic [2*W-1:0]     res_q,
  output logic               contention_q,
  output logic               idle_q
);
  import bus_res_pkg::*;

  localparam int LW = 2 * W;
  localparam int CW = 2 * N;

  logic [N*LW-1:0] contrib;
  logic [CW-1:0]   col [W];

  for (genvar d = 0; d < N; d++) begin : g_src
    bres_gate #(.W(W)) gate_i (
      .en      (drv_en[d]),
      .val     (drv_val[d*LW +: LW]),
      .contrib (contrib[d*LW +: LW])
    );
  end

  // regroup source-major words into bit-major columns
  always_comb begin
    for (int b = 0; b < W; b++) begin
      for (int d = 0; d < N; d++) begin
        col[b][2*d +: 2] = contrib[d*LW + 2*b +: 2];
      end
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    bres_lane #(.N(N)) lane_i (
      .col (col[b]),
      .res (res_comb[2*b +: 2])
    );
  end

  bres_flags #(.N(N)) flags_i (
    .en    (drv_en),
    .multi (contention),
    .none  (idle)
  );

  assign active_mask = drv_en;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        res_q        <= {W{LANE_Z}};
        contention_q <= 1'b0;
        idle_q       <= 1'b1;
      end else begin
        res_q        <= res_comb;
        contention_q <= contention;
        idle_q       <= idle;
      end
    end
  end else begin : g_pass
    assign res_q        = res_comb;
    assign contention_q = contention;
    assign idle_q       = idle;
  end
endmodule

// File: rtl/bus_resolver_chk.sv
module bus_resolver_chk #(
  parameter int N       = 4,
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     drv_en,
  input logic [N*2*W-1:0] drv_val,
  input logic [2*W-1:0]   res_comb,
  input logic             contention,
  input logic             idle,
  input logic [2*W-1:0]   res_q,
  input logic             contention_q,
  input logic             idle_q
);
  localparam int LW = 2 * W;

  logic [W-1:0] any_x, any_0, any_1;

  always_comb begin
    any_x = '0;
    any_0 = '0;
    any_1 = '0;
    for (int b = 0; b < W; b++) begin
      for (int d = 0; d < N; d++) begin
        if (drv_en[d]) begin
          if (drv_val[d*LW + 2*b +: 2] == 2'b11) any_x[b] = 1'b1;
          if (drv_val[d*LW + 2*b +: 2] == 2'b00) any_0[b] = 1'b1;
          if (drv_val[d*LW + 2*b +: 2] == 2'b01) any_1[b] = 1'b1;
        end
      end
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bitchk
    a_r4_x_dominates: assert property (@(posedge clk) disable iff (rst)
      any_x[b] |-> res_comb[2*b +: 2] == 2'b11);
    a_r3_clash_gives_x: assert property (@(posedge clk) disable iff (rst)
      (any_0[b] && any_1[b]) |-> res_comb[2*b +: 2] == 2'b11);
  end

  a_r6_idle_floats: assert property (@(posedge clk) disable iff (rst)
    idle |-> res_comb == {W{2'b10}});

  a_r7_single_quiet: assert property (@(posedge clk) disable iff (rst)
    $onehot(drv_en) |-> (!contention && !idle));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(contention && idle));

  if (REG_OUT) begin : g_regchk
    a_r9_copy_follows: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (res_q == $past(res_comb) && contention_q == $past(contention)
                && idle_q == $past(idle)));

    a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (res_q == {W{2'b10}} && !contention_q && idle_q));
  end
endmodule

bind bus_resolver bus_resolver_chk #(.N(N), .W(W), .REG_OUT(REG_OUT)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .drv_en       (drv_en),
  .drv_val      (drv_val),
  .res_comb     (res_comb),
  .contention   (contention),
  .idle         (idle),
  .res_q        (res_q),
  .contention_q (contention_q),
  .idle_q       (idle_q)
);

// File: tb/bus_resolver_tb_top.sv
module bus_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int NV = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     drv_en = '0;
  logic [N*2*W-1:0] drv_val = '0;
  logic [2*W-1:0]   res_comb, res_q;
  logic             contention, idle, contention_q, idle_q;
  logic [N-1:0]     active_mask;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_resolver #(.N(N), .W(W), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .drv_en(drv_en), .drv_val(drv_val),
    .res_comb(res_comb), .contention(contention), .idle(idle),
    .active_mask(active_mask), .res_q(res_q),
    .contention_q(contention_q), .idle_q(idle_q)
  );

  // codes per hex digit: 0 = two 0 bits, 5 = two 1 bits, A = two Z bits, F = two X bits
  localparam logic [N-1:0] V_EN [NV] = '{4'b0000, 4'b0001, 4'b0011, 4'b0011,
    4'b0110, 4'b1111, 4'b1000, 4'b0101, 4'b1010};
  localparam logic [63:0] V_DAT [NV] = '{
    64'h5555_5555_5555_5555,
    64'hFFFF_FFFF_FFFF_05AF,
    64'hFFFF_FFFF_0000_5555,
    64'h0000_0000_5555_5555,
    64'h5555_0F50_AAAA_0000,
    64'h000F_0000_0000_0000,
    64'hAAAA_0000_0000_0000,
    64'hFFFF_A05A_FFFF_50AA,
    64'h5A00_0000_0055_0000};
  localparam logic [15:0] V_EXP [NV] = '{16'hAAAA, 16'h05AF, 16'hFFFF, 16'h5555,
    16'h0F50, 16'h000F, 16'hAAAA, 16'h505A, 16'hF0FF};
  localparam logic V_CON [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic V_IDL [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam string V_TAG [NV] = '{"R2 R6 R8 all idle", "R1 R2 R5 lone driver",
    "R3 clash", "R5 R7 agreeing drivers", "R4 R6 enabled Z with X",
    "R4 X over zeros", "R6 R8 lone Z driver", "R3 R5 mixed bits", "R3 R2 clash mix"};

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    // reset state of the registered copy (R10)
    @(posedge clk); @(posedge clk); #1;
    check(64'(res_q), 64'hAAAA, "R10 reset res_q");
    check(64'({contention_q, idle_q}), 64'b01, "R10 reset flags");
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drv_en  = V_EN[i];
      drv_val = V_DAT[i];
      #1;
      check(64'(res_comb), 64'(V_EXP[i]), V_TAG[i]);
      check(64'({contention, idle}), 64'({V_CON[i], V_IDL[i]}), {V_TAG[i], " flags R7 R8"});
      check(64'(active_mask), 64'(V_EN[i]), "R8 active_mask");
      @(posedge clk); #1;
      check(64'(res_q), 64'(V_EXP[i]), {V_TAG[i], " R9 registered"});
      check(64'({contention_q, idle_q}), 64'({V_CON[i], V_IDL[i]}), "R9 registered flags");
    end

    // disabled driver toggling must not move the output (R2)
    @(negedge clk);
    drv_en  = 4'b0001;
    drv_val = 64'h0000_0000_0000_5A0F;
    #1;
    check(64'(res_comb), 64'h5A0F, "R2 before toggle");
    drv_val = 64'h5555_FFFF_0000_5A0F;
    #1;
    check(64'(res_comb), 64'h5A0F, "R2 after toggle");

    // reset during contention clears copy only (R10)
    @(negedge clk);
    drv_en  = 4'b0011;
    drv_val = 64'h0000_0000_0000_5555;
    rst     = 1'b1;
    @(posedge clk); #1;
    check(64'(res_q), 64'hAAAA, "R10 reset over traffic");
    check(64'({contention_q, idle_q}), 64'b01, "R10 reset flags over traffic");
    check(64'({res_comb, contention}), 64'({16'hFFFF, 1'b1}), "R10 comb unaffected");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(64'(res_q), 64'hFFFF, "R9 first copy after reset");
    check(64'(contention_q), 64'd1, "R9 R7 contention copy");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule